// File: doc/BRIEF.md
# Multilane Interleaved Test-Pattern Source

This block produces test traffic for a module whose internal gearbox regroups bits between its electrical and optical lanes. Twenty logical-lane sources run side by side, each one either a pseudorandom sequence or a 32-bit word that repeats. The sources are combined in pairs onto ten physical-lane outputs, one bit at a time. Each logical lane moves at half the rate of its physical lane, so each one stays a valid sequence after any bit-level mux or demux later in the chain.

A configuration port selects the sequence type for all lanes and the polynomial for all lanes. It also sets a word value and a start offset for each lane. A `start` pulse reloads every source from its seed. The block then spends a fixed alignment window moving each lane forward by its own offset, which removes any bit-level correlation between lanes. After that it streams one 16-bit word per physical lane on every clock.

Top module: `gbx_pattern_gen`

## Requirements
- R1: While `rst` is held, and after it until the first `start`, `out_valid` is 0 and `phy_data` is all zeros.
- R2: In sequence mode (control bit 0 = 0), each logical lane follows the recurrence fb = s[N-1] ^ s[T-1] and s <= {s, fb}, with the output bit equal to fb. The state is seeded with all ones. Control bits [2:1] select (N,T): 0 gives (7,6), 1 gives (15,14), 2 gives (23,18), 3 gives (31,28).
- R3: In word mode (control bit 0 = 1), each logical lane sends its own 32-bit word, starting at bit 31 and moving down, and repeats it without a gap.
- R4: Physical lane k occupies `phy_data[16k+15:16k]`. Bit 15-2j carries bit j (in time order) of logical lane 2k, and bit 14-2j carries bit j of logical lane 2k+1. Bit 15 is therefore the earliest bit, and it comes from the even lane.
- R5: A lane with offset d (0 to 1023) begins its first valid word at position d of its own sequence. This holds in both modes, and word mode wraps modulo 32.
- R6: After the clock edge that samples `start`, `out_valid` stays 0 for the 1024-cycle alignment window. It becomes 1 after the 1025th following edge, and then stays 1 with a new word on every clock.
- R7: A `start` pulse issued while streaming drops `out_valid` on the next edge and restarts every lane from its seed and offset.
- R8: Configuration map: address 0 is control, address 32+i is the word for lane i, and address 64+i holds the offset for lane i in bits [9:0]. A write to any other address has no effect on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 7 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| start | input | 1 | Reload the sources and begin alignment |
| out_valid | output | 1 | Physical-lane words are valid |
| phy_data | output | 160 | Ten 16-bit physical-lane words, lane k at bits [16k+15:16k] |

## Verification
All four polynomials are run with zero offsets, so a wrong tap or a wrong shift direction shows up as a mismatch in the first word. A spread of offsets from 0 to 1023, together with distinct words per lane that use offsets above 32, separates the offset and wrap logic from the sequence logic. One pattern puts all ones on the even lanes and all zeros on the odd lanes, which must give 0xAAAA on every physical lane and so pins down the interleave order. A run that follows writes to unmapped addresses shows whether the decoder aliases them into the lane registers.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  localparam int LFSR_W = 31;

  typedef enum logic [1:0] {POLY7, POLY15, POLY23, POLY31} poly_e;
  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ALIGN, SEQ_RUN} seq_e;

  function automatic logic lfsr_fb(logic [LFSR_W-1:0] s, poly_e p);
    case (p)
      POLY7:   return s[6]  ^ s[5];
      POLY15:  return s[14] ^ s[13];
      POLY23:  return s[22] ^ s[17];
      default: return s[30] ^ s[27];
    endcase
  endfunction

  function automatic logic [LFSR_W-1:0] lfsr_next(logic [LFSR_W-1:0] s, poly_e p);
    return {s[LFSR_W-2:0], lfsr_fb(s, p)};
  endfunction
endpackage

// File: rtl/gbx_cfg_regs.sv
module gbx_cfg_regs
  import gbx_pkg::*;
#(
  parameter int NUM_LOG = 20,
  parameter int WORD_W  = 32,
  parameter int OFS_W   = 10,
  parameter int AW      = 7
) (
  input  logic                             clk,
  input  logic                             rst,
  input  logic                             we,
  input  logic [AW-1:0]                    addr,
  input  logic [WORD_W-1:0]                wdata,
  output logic                             word_mode,
  output poly_e                            poly,
  output logic [NUM_LOG-1:0][WORD_W-1:0]   words,
  output logic [NUM_LOG-1:0][OFS_W-1:0]    ofs
);
  localparam int SPAN      = 1 << $clog2(NUM_LOG);
  localparam int WORD_BASE = SPAN;
  localparam int OFS_BASE  = 2 * SPAN;

  logic ctrl_hit;
  assign ctrl_hit = we && (addr == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      word_mode <= 1'b0;
      poly      <= POLY7;
    end else if (ctrl_hit) begin
      word_mode <= wdata[0];
      poly      <= poly_e'(wdata[2:1]);
    end
  end

  for (genvar i = 0; i < NUM_LOG; i++) begin : g_lane_regs
    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '0;
        ofs[i]   <= '0;
      end else if (we) begin
        if (addr == AW'(WORD_BASE + i)) words[i] <= wdata;
        if (addr == AW'(OFS_BASE + i))  ofs[i]   <= wdata[OFS_W-1:0];
      end
    end
  end

  // R8: the control fields move only on a write to their own address
  p_ctrl_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !(we && addr == '0) |=> ($stable(word_mode) && $stable(poly)));
endmodule

// File: rtl/gbx_lane_src.sv
module gbx_lane_src
  import gbx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int BITS   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              align_step,
  input  logic              adv,
  input  logic              word_mode,
  input  poly_e             poly,
  input  logic [WORD_W-1:0] word,
  output logic [BITS-1:0]   bits
);
  localparam int PTR_W = $clog2(WORD_W);

  logic [LFSR_W-1:0] lfsr;
  logic [PTR_W-1:0]  ptr;
  logic [LFSR_W-1:0] chain  [0:BITS];
  logic [PTR_W-1:0]  pchain [0:BITS];

  always_comb begin
    chain[0]  = lfsr;
    pchain[0] = ptr;
    for (int i = 0; i < BITS; i++) begin
      chain[i+1]  = lfsr_next(chain[i], poly);
      pchain[i+1] = pchain[i] + 1'b1;
      bits[i]     = word_mode ? word[PTR_W'(WORD_W-1) - pchain[i]] : chain[i+1][0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst || load) begin
      lfsr <= '1;
      ptr  <= '0;
    end else if (adv) begin
      lfsr <= chain[BITS];
      ptr  <= pchain[BITS];
    end else if (align_step) begin
      lfsr <= chain[1];
      ptr  <= pchain[1];
    end
  end
endmodule

// File: rtl/gbx_pair_mux.sv
module gbx_pair_mux #(
  parameter int BITS = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic [BITS-1:0]   even_bits,
  input  logic [BITS-1:0]   odd_bits,
  output logic [2*BITS-1:0] data,
  output logic              valid
);
  logic [2*BITS-1:0] mix;

  for (genvar j = 0; j < BITS; j++) begin : g_mix
    assign mix[2*BITS-1-2*j] = even_bits[j];
    assign mix[2*BITS-2-2*j] = odd_bits[j];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
    end else begin
      valid <= run;
      if (run) data <= mix;
    end
  end

  // R6: the valid flag tracks the streaming phase one cycle later
  p_valid_track_r6: assert property (@(posedge clk) disable iff (rst)
    run |=> valid);
  p_valid_idle_r6: assert property (@(posedge clk) disable iff (rst)
    !run |=> !valid);
endmodule

// File: rtl/gbx_pattern_gen.sv
module gbx_pattern_gen
  import gbx_pkg::*;
#(
  parameter int NUM_PHY = 10,
  parameter int PHY_W   = 16,
  parameter int WORD_W  = 32,
  parameter int OFS_W   = 10,
  parameter int CFG_AW  = 7
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [CFG_AW-1:0]        cfg_addr,
  input  logic [WORD_W-1:0]        cfg_wdata,
  input  logic                     start,
  output logic                     out_valid,
  output logic [NUM_PHY*PHY_W-1:0] phy_data
);
  localparam int NUM_LOG   = 2 * NUM_PHY;
  localparam int LANE_BITS = PHY_W / 2;

  logic                                word_mode;
  poly_e                               poly;
  logic [NUM_LOG-1:0][WORD_W-1:0]      words;
  logic [NUM_LOG-1:0][OFS_W-1:0]       ofs;
  logic [NUM_LOG-1:0][LANE_BITS-1:0]   lane_bits;
  logic [NUM_PHY-1:0]                  phy_valid;
  seq_e                                st;
  logic [OFS_W-1:0]                    cnt;
  logic                                run;

  gbx_cfg_regs #(.NUM_LOG(NUM_LOG), .WORD_W(WORD_W), .OFS_W(OFS_W), .AW(CFG_AW)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .word_mode(word_mode), .poly(poly), .words(words), .ofs(ofs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st  <= SEQ_IDLE;
      cnt <= '0;
    end else if (start) begin
      st  <= SEQ_ALIGN;
      cnt <= '0;
    end else if (st == SEQ_ALIGN) begin
      cnt <= cnt + 1'b1;
      if (cnt == '1) st <= SEQ_RUN;
    end
  end

  assign run = (st == SEQ_RUN) && !start;

  for (genvar i = 0; i < NUM_LOG; i++) begin : g_lane
    gbx_lane_src #(.WORD_W(WORD_W), .BITS(LANE_BITS)) u_src (
      .clk(clk), .rst(rst), .load(start),
      .align_step((st == SEQ_ALIGN) && (cnt < ofs[i])),
      .adv(run), .word_mode(word_mode), .poly(poly),
      .word(words[i]), .bits(lane_bits[i])
    );
  end

  for (genvar k = 0; k < NUM_PHY; k++) begin : g_phy
    gbx_pair_mux #(.BITS(LANE_BITS)) u_mux (
      .clk(clk), .rst(rst), .run(run),
      .even_bits(lane_bits[2*k]), .odd_bits(lane_bits[2*k+1]),
      .data(phy_data[k*PHY_W +: PHY_W]), .valid(phy_valid[k])
    );
  end

  assign out_valid = phy_valid[0];

  // R6: no output during the alignment window
  p_quiet_align_r6: assert property (@(posedge clk) disable iff (rst)
    (st == SEQ_ALIGN) |-> !out_valid);
  // R6: streaming begins only once the window has run its full length
  p_align_len_r6: assert property (@(posedge clk) disable iff (rst)
    ($past(st) == SEQ_ALIGN && st == SEQ_RUN) |-> ($past(cnt) == '1));
  // R7: a restart silences the output on the next edge
  p_restart_r7: assert property (@(posedge clk) disable iff (rst)
    start |=> !out_valid);
  // R1/R6: all physical lanes agree on validity
  p_lanes_agree_r1: assert property (@(posedge clk) disable iff (rst)
    (phy_valid == '0) || (phy_valid == '1));
endmodule

// File: tb/gbx_pattern_gen_test.sv
module gbx_pattern_gen_test;
  localparam int NP = 10;
  localparam int NL = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [6:0]    cfg_addr = '0;
  logic [31:0]   cfg_wdata = '0;
  logic          start = 1'b0;
  logic          out_valid;
  logic [NP*16-1:0] phy_data;

  int checks = 0;
  int fails  = 0;

  logic [31:0] bw [NL];
  logic [9:0]  bo [NL];
  logic        bmode;
  logic [1:0]  bpoly;
  logic [30:0] ml [NL];
  int          mp [NL];

  gbx_pattern_gen uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .start(start), .out_valid(out_valid), .phy_data(phy_data)
  );

  always #4 clk = ~clk;

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  function automatic logic model_bit(int i);
    logic f, b;
    case (bpoly)
      2'd0: f = ml[i][6]  ^ ml[i][5];
      2'd1: f = ml[i][14] ^ ml[i][13];
      2'd2: f = ml[i][22] ^ ml[i][17];
      default: f = ml[i][30] ^ ml[i][27];
    endcase
    ml[i] = {ml[i][29:0], f};
    b = bmode ? bw[i][31 - mp[i]] : f;
    mp[i] = (mp[i] + 1) % 32;
    return b;
  endfunction

  task automatic load_all();
    wr(7'd0, {29'd0, bpoly, bmode});
    for (int i = 0; i < NL; i++) begin
      wr(7'(32 + i), bw[i]);
      wr(7'(64 + i), {22'd0, bo[i]});
    end
  endtask

  // Pulse start, measure the alignment window, then compare nwords words per lane
  task automatic run_check(string req, int nwords);
    int n;
    logic [7:0]  lb [NL];
    logic [15:0] e;
    for (int i = 0; i < NL; i++) begin
      ml[i] = '1; mp[i] = 0;
      for (int s = 0; s < int'(bo[i]); s++) void'(model_bit(i));
    end
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check("R7 valid low after start", 32'(out_valid), 32'd0);
    n = 1;
    while (!out_valid && n < 3000) begin @(negedge clk); n++; end
    check("R6 alignment length", n, 1026);
    for (int w = 0; w < nwords; w++) begin
      for (int i = 0; i < NL; i++)
        for (int j = 0; j < 8; j++) lb[i][j] = model_bit(i);
      for (int k = 0; k < NP; k++) begin
        for (int j = 0; j < 8; j++) begin
          e[15-2*j] = lb[2*k][j];
          e[14-2*j] = lb[2*k+1][j];
        end
        check(req, {16'd0, phy_data[k*16 +: 16]}, {16'd0, e});
      end
      check("R6 valid held", 32'(out_valid), 32'd1);
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check("R1 valid in reset", 32'(out_valid), 32'd0);
    check("R1 data in reset", 32'(phy_data[31:0]), 32'd0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check("R1 valid idle", 32'(out_valid), 32'd0);
    check("R1 data idle", 32'(phy_data[159:128]), 32'd0);
  endtask

  task automatic t_polys();
    bmode = 1'b0;
    for (int i = 0; i < NL; i++) begin bo[i] = '0; bw[i] = '0; end
    for (int p = 0; p < 4; p++) begin
      bpoly = 2'(p);
      load_all();
      run_check("R2 sequence", 12);
    end
  endtask

  task automatic t_offsets();
    bmode = 1'b0; bpoly = 2'd3;
    for (int i = 0; i < NL; i++) bo[i] = 10'((i * 157) % 1024);
    bo[0] = 10'd0; bo[NL-1] = 10'd1023; bo[5] = 10'd1;
    load_all();
    run_check("R5 sequence offset", 10);
  endtask

  task automatic t_words();
    bmode = 1'b1; bpoly = 2'd1;
    for (int i = 0; i < NL; i++) begin
      bw[i] = 32'h1357_9BDF ^ (i * 32'h0101_0111);
      bo[i] = 10'((i * 11) % 70);
    end
    bo[3] = 10'd33; bo[4] = 10'd1023;
    load_all();
    run_check("R3 word repeat", 10);
  endtask

  task automatic t_interleave();
    bmode = 1'b1;
    for (int i = 0; i < NL; i++) begin
      bw[i] = (i % 2 == 0) ? 32'hFFFF_FFFF : 32'h0;
      bo[i] = '0;
    end
    load_all();
    run_check("R4 model", 2);
    for (int k = 0; k < NP; k++)
      check("R4 even bit first", {16'd0, phy_data[k*16 +: 16]}, 32'h0000_AAAA);
  endtask

  task automatic t_unmapped();
    bmode = 1'b1;
    for (int i = 0; i < NL; i++) begin
      bw[i] = 32'hA5C3_0000 | 32'(i * 7);
      bo[i] = 10'(i);
    end
    load_all();
    wr(7'd1, 32'h0000_0006);
    wr(7'd52, 32'hDEAD_BEEF);
    wr(7'd63, 32'h1234_5678);
    wr(7'd84, 32'h0000_0155);
    wr(7'd127, 32'hFFFF_FFFF);
    run_check("R8 unmapped write ignored", 8);
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    bmode = 1'b0; bpoly = 2'd0;
    t_reset();
    t_polys();
    t_offsets();
    t_words();
    t_interleave();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule